// File: doc/BRIEF.md
# Transmit Frame Assembler

This block builds the complete byte sequence of one short-range wireless frame from a payload supplied by a host. The host picks one of two ways to feed it. In buffered mode the host first writes the whole payload into a local byte RAM and then pulses a start request. In streaming mode the host pulses start and then hands over 16-bit payload words one at a time, each in answer to an interrupt pulse. The block adds the synchronisation header and the length byte in front of the payload. It appends a 16-bit CRC after the last payload byte.

Bytes leave on an 8-bit port with a valid/ready handshake toward the spreading and modulation stages. Each frame goes out as four zero bytes, a start marker, a length byte, the payload and two check bytes. A length of zero or above the maximum is refused with a one-cycle error pulse. In streaming mode, a word that arrives too late aborts the frame and sets a sticky underrun flag.

Top module: `tx_frame_assembler`

## Requirements
- R1: A frame is sent as four bytes of 0x00, then 0xA7, then a byte equal to the payload length plus 2, then the payload bytes in order, then the two check bytes.
- R2: A start with `frame_len` from 1 to MAX_LEN (125) is accepted. A start with `frame_len` of 0 or above MAX_LEN raises `len_err` for one cycle, starting the cycle after the request, and keeps `busy` and `out_valid` low.
- R3: The check value is a CRC-16 over the payload bytes only. It uses polynomial x^16+x^12+x^5+1, initial value 0, and takes each byte LSB first. It is sent low byte first. The payload "123456789" gives 0x89, then 0x21.
- R4: In buffered mode (`mode_stream`=0), payload byte i is read from RAM address i, as written through `buf_we`/`buf_addr`/`buf_wdata`. `irq` pulses exactly once per frame, in the cycle after the last check byte is transferred.
- R5: In streaming mode (`mode_stream`=1), `irq` pulses once per needed word. The first pulse comes in the cycle after the accepted start. Each later pulse comes in the cycle after the last used byte of the previous word is transferred. That makes ceil(len/2) pulses in total and no completion pulse. Bits [7:0] of a word are sent before bits [15:8], and the upper byte of the final word of an odd-length payload is dropped.
- R6: If no `word_valid` arrives within WORD_TIMEOUT cycles of a word request, the frame is aborted: `busy` and `out_valid` fall and the check bytes are not sent. `underrun` rises at the same point and stays set until the next accepted start clears it.
- R7: A start request while `busy` is high is ignored. The frame in flight is unchanged and `len_err` does not rise.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A byte advances only on a cycle where both are high.
- R9: `busy` is high from the cycle after an accepted start until the cycle after the final transfer, or until an abort.
- R10: `word_valid` while no word request is outstanding has no effect on the bytes sent.
- R11: After reset, `out_valid`, `busy`, `irq`, `len_err` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_stream | input | 1 | 0 = buffered, 1 = streaming; sampled at start |
| start | input | 1 | Transmit request pulse |
| frame_len | input | 7 | Payload length in bytes; sampled at start |
| buf_we | input | 1 | Payload RAM write enable |
| buf_addr | input | 7 | Payload RAM write address |
| buf_wdata | input | 8 | Payload RAM write data |
| word_valid | input | 1 | Streaming word strobe |
| word_data | input | 16 | Streaming word, low byte sent first |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Interrupt pulse (word request or frame done) |
| busy | output | 1 | Frame in progress |
| len_err | output | 1 | Rejected-length pulse |
| underrun | output | 1 | Sticky streaming underrun flag |

## Verification
Results appear at these points:
- `busy` and `len_err` settle one cycle after the start request.
- A word request shows on `irq` one cycle after the start, or after the transfer that used up a word.
- The completion pulse follows the final transfer by one cycle.
- `underrun` appears WORD_TIMEOUT cycles after an unanswered request.

The bench drives all inputs on the falling edge and samples the outputs on that same falling edge. That is half a cycle after the rising edge that updated them. A byte is counted as transferred only when valid and ready were both high at that sample point, so the count matches the edge at which the design advances. Host words are returned at a chosen number of whole cycles after the request is sampled. That keeps every delay on a known side of the deadline.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

    localparam int          PREAMBLE_LEN  = 4;
    localparam logic [7:0]  PREAMBLE_BYTE = 8'h00;
    localparam logic [7:0]  SOF_BYTE      = 8'hA7;
    localparam int          FCS_LEN       = 2;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_LEN,
        ST_PAY,
        ST_FCS_LO,
        ST_FCS_HI
    } tx_state_e;

    // one byte of the reflected CRC-16, bit 0 first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tfa_crc16.sv
module tfa_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import tfa_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (upd)   crc <= crc16_step(crc, din);
    end

    // R3: the value only moves on a payload byte
    p_crc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd) |=> $stable(crc));

endmodule

// File: rtl/tfa_payload_ram.sv
module tfa_payload_ram #(
    parameter int DEPTH = 125,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/tfa_stream_feed.sv
module tfa_stream_feed #(
    parameter int CW      = 7,
    parameter int TIMEOUT = 32,
    localparam int TMR_W  = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          begin_i,
    input  logic [CW-1:0] nwords_i,
    input  logic          word_valid_i,
    input  logic [15:0]   word_data_i,
    input  logic          take_i,
    input  logic          last_i,
    output logic          have_o,
    output logic [7:0]    byte_o,
    output logic          req_o,
    output logic          timeout_o
);
    logic [15:0]      wreg_q;
    logic             half_q;
    logic             waiting_q;
    logic [CW-1:0]    left_q;
    logic [TMR_W-1:0] tmr_q;

    assign byte_o    = half_q ? wreg_q[15:8] : wreg_q[7:0];
    assign timeout_o = waiting_q && !word_valid_i && (tmr_q == TMR_W'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wreg_q    <= '0;
            half_q    <= 1'b0;
            waiting_q <= 1'b0;
            have_o    <= 1'b0;
            left_q    <= '0;
            tmr_q     <= '0;
            req_o     <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (begin_i) begin
                waiting_q <= 1'b1;
                req_o     <= 1'b1;
                tmr_q     <= '0;
                have_o    <= 1'b0;
                half_q    <= 1'b0;
                left_q    <= nwords_i - 1'b1;
            end else if (timeout_o) begin
                waiting_q <= 1'b0;
                have_o    <= 1'b0;
                left_q    <= '0;
            end else if (waiting_q) begin
                if (word_valid_i) begin
                    wreg_q    <= word_data_i;
                    have_o    <= 1'b1;
                    half_q    <= 1'b0;
                    waiting_q <= 1'b0;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end else if (take_i) begin
                if (!half_q && !last_i) begin
                    half_q <= 1'b1;
                end else begin
                    have_o <= 1'b0;
                    if (left_q != '0) begin
                        left_q    <= left_q - 1'b1;
                        waiting_q <= 1'b1;
                        req_o     <= 1'b1;
                        tmr_q     <= '0;
                    end
                end
            end
        end
    end

    // R5: each request is a single-cycle pulse
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);
    // R10: a word is only captured while a request is outstanding
    p_word_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        !waiting_q |=> $stable(wreg_q));
    // R6: a missed deadline leaves nothing buffered and nothing requested
    p_timeout_clears_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> (!have_o && !req_o));

endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler #(
    parameter int  MAX_LEN      = 125,
    parameter int  WORD_TIMEOUT = 32,
    localparam int LEN_W        = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_stream,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             buf_we,
    input  logic [LEN_W-1:0] buf_addr,
    input  logic [7:0]       buf_wdata,
    input  logic             word_valid,
    input  logic [15:0]      word_data,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             irq,
    output logic             busy,
    output logic             len_err,
    output logic             underrun
);
    import tfa_pkg::*;

    tx_state_e        state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic             mode_q;
    logic             done_irq_q;

    logic             len_ok, accept, fire, last_pay;
    logic [7:0]       ram_byte, feed_byte;
    logic             feed_have, feed_req, feed_timeout;
    logic [15:0]      crc;
    logic [LEN_W-1:0] nwords;

    assign len_ok   = (frame_len != '0) && (int'(frame_len) <= MAX_LEN);
    assign accept   = start && (state_q == ST_IDLE) && len_ok;
    assign last_pay = (idx_q == len_q - 1'b1);
    assign busy     = (state_q != ST_IDLE);
    assign fire     = out_valid && out_ready;
    assign irq      = done_irq_q | feed_req;
    assign nwords   = (frame_len >> 1) + {{(LEN_W-1){1'b0}}, frame_len[0]};

    always_comb begin
        out_valid = (state_q != ST_IDLE);
        out_data  = PREAMBLE_BYTE;
        unique case (state_q)
            ST_PRE:    out_data = PREAMBLE_BYTE;
            ST_SOF:    out_data = SOF_BYTE;
            ST_LEN:    out_data = 8'(len_q) + 8'(FCS_LEN);
            ST_PAY: begin
                out_data = mode_q ? feed_byte : ram_byte;
                if (mode_q) out_valid = feed_have;
            end
            ST_FCS_LO: out_data = crc[7:0];
            ST_FCS_HI: out_data = crc[15:8];
            default:   out_data = PREAMBLE_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            len_q      <= '0;
            idx_q      <= '0;
            mode_q     <= 1'b0;
            done_irq_q <= 1'b0;
            len_err    <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            done_irq_q <= 1'b0;
            len_err    <= start && (state_q == ST_IDLE) && !len_ok;
            if (accept) begin
                state_q  <= ST_PRE;
                idx_q    <= '0;
                len_q    <= frame_len;
                mode_q   <= mode_stream;
                underrun <= 1'b0;
            end else if (feed_timeout) begin
                state_q  <= ST_IDLE;
                underrun <= 1'b1;
            end else if (fire) begin
                unique case (state_q)
                    ST_PRE: begin
                        if (idx_q == LEN_W'(PREAMBLE_LEN - 1)) begin
                            state_q <= ST_SOF;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    ST_SOF: state_q <= ST_LEN;
                    ST_LEN: state_q <= ST_PAY;
                    ST_PAY: begin
                        if (last_pay) state_q <= ST_FCS_LO;
                        else          idx_q   <= idx_q + 1'b1;
                    end
                    ST_FCS_LO: state_q <= ST_FCS_HI;
                    ST_FCS_HI: begin
                        state_q    <= ST_IDLE;
                        done_irq_q <= !mode_q;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    tfa_payload_ram #(.DEPTH(MAX_LEN), .AW(LEN_W)) u_ram (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (idx_q),
        .rdata (ram_byte)
    );

    tfa_stream_feed #(.CW(LEN_W), .TIMEOUT(WORD_TIMEOUT)) u_feed (
        .clk          (clk),
        .rst          (rst),
        .begin_i      (accept && mode_stream),
        .nwords_i     (nwords),
        .word_valid_i (word_valid),
        .word_data_i  (word_data),
        .take_i       (fire && (state_q == ST_PAY) && mode_q),
        .last_i       (last_pay),
        .have_o       (feed_have),
        .byte_o       (feed_byte),
        .req_o        (feed_req),
        .timeout_o    (feed_timeout)
    );

    tfa_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .upd (fire && (state_q == ST_PAY)),
        .din (out_data),
        .crc (crc)
    );

    // R8: a stalled byte holds unless the frame is aborted
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ((out_valid && $stable(out_data)) || $rose(underrun)));
    // R2: an out-of-range length is refused and nothing starts
    p_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !len_ok) |=> (len_err && !busy));
    // R7: a request during a frame changes nothing
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> ($stable(len_q) && !len_err));
    // R4: buffered frames end with the interrupt and busy released together
    p_done_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && state_q == ST_FCS_HI && !mode_q) |=> (irq && !busy));
    // R6: the underrun flag is sticky until a new accepted start
    p_urun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (underrun && !accept) |=> underrun);
    // R9: busy only drops after the last byte or on an abort
    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state_q == ST_FCS_HI) || $rose(underrun)));

endmodule

// File: tb/tb_tx_frame_assembler.sv
module tb_tx_frame_assembler;

    localparam int MAXL = 125;
    localparam int TMO  = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_stream = 1'b0, start = 1'b0, buf_we = 1'b0, word_valid = 1'b0, out_ready = 1'b0;
    logic [6:0]  frame_len = '0, buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic [15:0] word_data = '0;
    logic [7:0]  out_data;
    logic        out_valid, irq, busy, len_err, underrun;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] pay [0:127];
    logic [7:0] got [0:255];

    always #2 clk = ~clk;

    tx_frame_assembler #(.MAX_LEN(MAXL), .WORD_TIMEOUT(TMO)) dut (
        .clk(clk), .rst(rst), .mode_stream(mode_stream), .start(start), .frame_len(frame_len),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .word_valid(word_valid), .word_data(word_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .irq(irq), .busy(busy), .len_err(len_err), .underrun(underrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ pay[i][b];
                c = {1'b0, c[15:1]};
                if (fb) c = c ^ 16'h8408;
            end
        return c;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run_frame(input bit smode, input int n, input int rdy_pct, input int dmax,
                             input int miss_word, input bit junk, input bit busy_start);
        int k = 0, irqs = 0, wi = 0, due = -1, junk_at = -1;
        bit pend = 0, err_seen = 0, stall_bad = 0, pv = 0, pr = 1, pay_ok = 1, pre_ok = 1;
        logic [7:0] pd = '0;
        logic [15:0] c;
        if (!smode) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); buf_we = 1; buf_addr = 7'(i); buf_wdata = pay[i];
            end
            @(negedge clk); buf_we = 0;
        end
        @(negedge clk); mode_stream = smode; frame_len = 7'(n); start = 1; out_ready = 0;
        @(negedge clk); start = 0;
        check(busy == 1, "R9 busy after accepted start", busy, 1);
        for (int t = 0; t < 20000; t++) begin
            word_valid = 0;
            start = 0;
            if (len_err) err_seen = 1;
            if (irq) begin
                irqs++;
                if (smode) begin
                    pend = 1;
                    due = t + ((wi == miss_word) ? 100000 : int'($urandom_range(dmax, 0)));
                end
            end
            if (!busy) break;
            if (pend && t == due) begin
                word_valid = 1; word_data = {pay[2*wi+1], pay[2*wi]};
                pend = 0; wi++;
                if (junk) junk_at = t + 1;
            end else if (t == junk_at) begin
                word_valid = 1; word_data = 16'hDEAD;
            end
            if (busy_start && t == 7) begin start = 1; frame_len = 7'd3; end
            if (pv && !pr && !(out_valid && out_data == pd) && !underrun) stall_bad = 1;
            pv = out_valid; pd = out_data;
            pr = ($urandom_range(99, 0) < rdy_pct);
            out_ready = pr;
            if (out_valid && pr) begin got[k] = out_data; k++; end
            @(negedge clk);
        end
        out_ready = 0; word_valid = 0; start = 0;
        if (miss_word < 0) begin
            check(k == n + 8, "R1 byte count", k, n + 8);
            for (int i = 0; i < 4; i++) if (got[i] != 8'h00) pre_ok = 0;
            check(pre_ok, "R1 preamble zeros", got[0], 0);
            check(got[4] == 8'hA7, "R1 start marker", got[4], 8'hA7);
            check(got[5] == 8'(n + 2), "R1 length byte", got[5], n + 2);
            for (int i = 0; i < n; i++) if (got[6+i] != pay[i]) pay_ok = 0;
            if (smode) check(pay_ok, "R5 streamed payload order", 0, 1);
            else       check(pay_ok, "R4 buffered payload", 0, 1);
            c = ref_crc(n);
            check({got[n+7], got[n+6]} == c, "R3 check bytes", {got[n+7], got[n+6]}, c);
            if (smode) check(irqs == (n + 1) / 2, "R5 word request count", irqs, (n + 1) / 2);
            else       check(irqs == 1, "R4 single completion irq", irqs, 1);
            check(underrun == 0, "R6 underrun clear on good frame", underrun, 0);
            check(!stall_bad, "R8 hold while stalled", stall_bad, 0);
            if (busy_start) check(!err_seen, "R7 start while busy ignored", err_seen, 0);
            if (junk) check(pay_ok, "R10 stray word ignored", 0, 1);
        end else begin
            check(underrun == 1, "R6 underrun set", underrun, 1);
            check(k < n + 8, "R6 frame aborted early", k, n + 8);
            check(!busy && !out_valid, "R6 busy and valid dropped", {busy, out_valid}, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic try_reject(input int n);
        @(negedge clk); mode_stream = 0; frame_len = 7'(n); start = 1;
        @(negedge clk); start = 0;
        check(len_err && !busy && !out_valid, "R2 length rejected", {len_err, busy, out_valid}, 3'b100);
        @(negedge clk);
        check(!len_err && !busy, "R2 error is one pulse", {len_err, busy}, 0);
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!out_valid && !busy && !irq && !len_err && !underrun, "R11 reset state",
              {out_valid, busy, irq, len_err, underrun}, 0);

        try_reject(0);
        try_reject(126);
        try_reject(127);

        // R3 known vector "123456789"
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
        check(ref_crc(9) == 16'h2189, "R3 reference crc", ref_crc(9), 16'h2189);
        run_frame(0, 9, 100, 1, -1, 0, 0);
        check(got[15] == 8'h89 && got[16] == 8'h21, "R3 known vector bytes", {got[15], got[16]}, 16'h8921);

        for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);
        run_frame(0, 1, 100, 1, -1, 0, 0);
        run_frame(0, 125, 60, 1, -1, 0, 0);
        run_frame(1, 1, 100, 0, -1, 0, 0);
        run_frame(1, 2, 50, 5, -1, 0, 0);
        run_frame(1, 125, 70, 10, -1, 0, 0);
        run_frame(0, 20, 40, 1, -1, 0, 1);
        run_frame(1, 20, 40, 6, -1, 0, 1);

        // R10: stray word while idle, then during a frame
        @(negedge clk); word_valid = 1; word_data = 16'hFFFF;
        @(negedge clk); word_valid = 0;
        run_frame(1, 17, 80, 8, -1, 1, 0);

        // R6: miss the first word, then a later word, then recover
        run_frame(1, 10, 100, 3, 0, 0, 0);
        run_frame(1, 20, 70, 3, 3, 0, 0);
        run_frame(1, 11, 90, 4, -1, 0, 0);

        for (int f = 0; f < 16; f++) begin
            for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);
            run_frame(1'($urandom), int'($urandom_range(MAXL, 1)), int'($urandom_range(100, 30)),
                      int'($urandom_range(20, 0)), -1, 1'($urandom), 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule